// File: doc/BRIEF.md
# Mode-Selected PLL Control Core

This block is the digital heart of a frequency-synthesiser loop. A reference divider turns the reference clock into a comparison clock, at a ratio picked by a 3-bit mode input. A 15-bit programmable divider counts rising edges of the prescaled RF signal and produces the feedback event. A phase-frequency detector compares the two events and drives charge-pump up and down requests. A lock detector watches the width of those requests. It raises a lock flag after a run of clean comparison periods and uses it to choose between the high and low pump current.

A test decoder, enabled by a dedicated input, reads three of the port bits. It can force the pump direction and current, force the lock flag either way, or route the comparison clock and a halved feedback signal onto two port pins. A pump-disable input silences both pump requests. The whole core runs on the reference clock. The prescaled RF input is brought in through a synchroniser and must toggle at less than half the reference rate.

Top module: `pllc_core`

## Requirements
- R1: The comparison period is 640 reference cycles for mode 0, 2048 for mode 1, 1024 for mode 2, 1280 for mode 3 and 512 for mode 4. Modes 5, 6 and 7 give 640. A mode change takes effect when the current period ends.
- R2: The feedback divider emits one event per D rising edges of `rf_in`, where D is `divisor`; a divisor of 0 acts as 1. In routing test mode, `port_on[3]` toggles on every feedback event, so its period is 2·D RF edges.
- R3: `pump_up` is set by a comparison event and `pump_dn` by a feedback event. When both are pending, both clear. The two are never high together. If feedback stops, `pump_up` stays high after the next comparison event.
- R4: `lock_flag` (1 = in lock) rises one cycle after the comparison event that closes the 8th consecutive period in which no pump request lasted `LOCK_WIN` cycles.
- R5: Once a single pump request has lasted `LOCK_WIN` cycles, lock is cleared on the next cycle and the clean-period count restarts.
- R6: Outside pump-forcing test codes, `pump_hi` is 1 while out of lock and 0 while in lock.
- R7: While `pump_dis` is 1, `pump_up` and `pump_dn` are both 0, including in test mode. This has no effect on the internal detector state.
- R8: Let P1, P2 and P3 be `port_bits[1]`, `port_bits[2]` and `port_bits[3]`. With `test_en`=1 and P2=0, `pump_up` = P3, `pump_dn` = not P3 and `pump_hi` = not P1. The four codes (P1,P2,P3) are 000 = down/high, 001 = up/high, 100 = down/low and 101 = up/low.
- R9: With `test_en`=1, P2=1 and P3=0, `port_on[2]` carries the comparison clock, `port_on[3]` carries the halved feedback signal, `port_on[1:0]` follow `port_bits[1:0]`, and `lock_flag` is 0.
- R10: With `test_en`=1, P2=1 and P3=1, `lock_flag` is 1.
- R11: With `test_en`=0, `port_on` equals `port_bits` (1 = port sinking).
- R12: During reset `pump_up`, `pump_dn` and `lock_flag` are 0 and `pump_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Reference ratio select |
| rf_in | input | 1 | Prescaled RF signal, asynchronous |
| divisor | input | 15 | Feedback divide word |
| port_bits | input | 4 | Programmed port bits P0..P3 |
| test_en | input | 1 | Enables test-code decoding |
| pump_dis | input | 1 | Forces both pump requests inactive |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| pump_hi | output | 1 | 1 selects high pump current |
| lock_flag | output | 1 | 1 when in lock |
| port_on | output | 4 | Port sink enables |

## Verification
The test, disable and port overrides act in the same cycle, so the bench changes inputs at a falling edge and samples one time step later. A comparison or feedback period is measured as the gap between two sampled rises on a routed port pin. The first gap after a mode or divisor change is discarded, because the change only lands at the next terminal count. Lock appears one cycle after the 8th clean comparison event and the pulse-width clear one cycle after the threshold. The lock checks are therefore placed several whole comparison periods away from those events, so that the RF synchroniser's phase offset cannot move the result across a check.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

    // Test decoder states derived from test enable and port bits P2/P3.
    typedef enum logic [1:0] {
        TM_OFF    = 2'd0,
        TM_PUMP   = 2'd1,
        TM_ROUTE  = 2'd2,
        TM_LOCKED = 2'd3
    } tmode_e;

    // Reference divide ratio per mode; unused codes fall back to mode 0.
    function automatic int mode_ratio(input logic [2:0] m);
        case (m)
            3'd1:    return 2048;
            3'd2:    return 1024;
            3'd3:    return 1280;
            3'd4:    return 512;
            default: return 640;
        endcase
    endfunction

endpackage

// File: rtl/pllc_ref_div.sv
// Reference divider: counts reference cycles down from the mode ratio and
// flags the terminal count as the comparison event. Assumes CNT_W holds the
// largest ratio. The ratio is re-read only at terminal count.
module pllc_ref_div
    import pllc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    output logic       cmp_tick,
    output logic       cmp_clk
);
    logic [CNT_W-1:0] ratio_sel;
    logic [CNT_W-1:0] ratio_q;
    logic [CNT_W-1:0] cnt_q;

    assign ratio_sel = CNT_W'(mode_ratio(mode));

    // Down-counter with reload of the current mode ratio at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= ratio_sel;
            cnt_q   <= ratio_sel - CNT_W'(1);
        end else if (cnt_q == '0) begin
            ratio_q <= ratio_sel;
            cnt_q   <= ratio_sel - CNT_W'(1);
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cmp_tick = (cnt_q == '0);
    assign cmp_clk  = (cnt_q < (ratio_q >> 1));

endmodule

// File: rtl/pllc_fb_div.sv
// Feedback divider: synchronises the prescaled RF signal, detects its rising
// edges and emits one registered event every `divisor` edges. Assumes RF
// toggles slower than half the reference rate. A divisor of 0 acts as 1.
module pllc_fb_div #(
    parameter int DIV_W       = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_in,
    input  logic [DIV_W-1:0] divisor,
    output logic             fb_tick,
    output logic             fb_half
);
    logic [SYNC_STAGES:0] sync_q;
    logic                 rf_rise;
    logic [DIV_W-1:0]     load_val;
    logic [DIV_W-1:0]     cnt_q;

    // Synchroniser chain plus one extra stage for edge detection.
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the asynchronous RF input.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= rf_in;
                end
            end else begin : g_next
                // Later stages shift the sampled value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign rf_rise  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign load_val = (divisor == '0) ? '0 : divisor - DIV_W'(1);

    // Edge counter with reload at terminal count; event and half-rate toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= load_val;
            fb_tick <= 1'b0;
            fb_half <= 1'b0;
        end else begin
            fb_tick <= 1'b0;
            if (rf_rise) begin
                if (cnt_q == '0) begin
                    cnt_q   <= load_val;
                    fb_tick <= 1'b1;
                    fb_half <= ~fb_half;
                end else begin
                    cnt_q <= cnt_q - DIV_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pllc_pfd.sv
// Phase-frequency detector: a comparison event sets up, a feedback event sets
// down, and when both are pending both clear. Up and down never coexist.
module pllc_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fb_tick,
    output logic up,
    output logic dn
);
    logic up_n;
    logic dn_n;

    // Next-state of the two request flops with mutual reset.
    always_comb begin
        up_n = up | ref_tick;
        dn_n = dn | fb_tick;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    // Request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_n;
            dn <= dn_n;
        end
    end

endmodule

// File: rtl/pllc_lock_det.sv
// Lock detector: measures each pump request in reference cycles. A request
// reaching WIN cycles is "wide" and drops lock at once; PERIODS consecutive
// comparison periods without a wide request declare lock.
module pllc_lock_det #(
    parameter int WIN     = 16,
    parameter int PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic dn,
    input  logic ref_tick,
    output logic wide,
    output logic locked
);
    localparam int WID_W = $clog2(WIN + 1);
    localparam int CNT_W = $clog2(PERIODS + 1);

    logic             active;
    logic [WID_W-1:0] wid_q;
    logic [CNT_W-1:0] good_q;
    logic             bad_q;

    assign active = up | dn;
    assign wide   = (wid_q == WID_W'(WIN));

    // Saturating width counter of the current pump request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wid_q <= '0;
        else if (!active)               wid_q <= '0;
        else if (wid_q != WID_W'(WIN))  wid_q <= wid_q + WID_W'(1);
    end

    // Marks the current comparison period as spoiled by a wide request.
    always_ff @(posedge clk) begin
        if (!rst_n)        bad_q <= 1'b0;
        else if (wide)     bad_q <= 1'b1;
        else if (ref_tick) bad_q <= 1'b0;
    end

    // Clean-period counter and lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (wide) begin
            good_q <= '0;
            locked <= 1'b0;
        end else if (ref_tick) begin
            if (bad_q) begin
                good_q <= '0;
                locked <= 1'b0;
            end else begin
                if (good_q != CNT_W'(PERIODS)) good_q <= good_q + CNT_W'(1);
                if (good_q >= CNT_W'(PERIODS - 1)) locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pllc_core.sv
// PLL control core top: reference and feedback dividers, phase-frequency
// detector, lock detector, and the test and disable overrides on the outputs.
// Assumes one reference clock domain; rf_in is asynchronous and slow.
module pllc_core
    import pllc_pkg::*;
#(
    parameter int REF_CNT_W   = 12,
    parameter int DIV_W       = 15,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_WIN    = 16,
    parameter int LOCK_PERIODS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             rf_in,
    input  logic [DIV_W-1:0] divisor,
    input  logic [3:0]       port_bits,
    input  logic             test_en,
    input  logic             pump_dis,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_hi,
    output logic             lock_flag,
    output logic [3:0]       port_on
);
    logic   cmp_tick;
    logic   cmp_clk;
    logic   fb_tick;
    logic   fb_half;
    logic   pfd_up;
    logic   pfd_dn;
    logic   pulse_wide;
    logic   lock_q;
    tmode_e tmode;
    logic   up_sel;
    logic   dn_sel;

    pllc_ref_div #(.CNT_W(REF_CNT_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cmp_tick (cmp_tick),
        .cmp_clk  (cmp_clk)
    );

    pllc_fb_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_fb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rf_in   (rf_in),
        .divisor (divisor),
        .fb_tick (fb_tick),
        .fb_half (fb_half)
    );

    pllc_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (cmp_tick),
        .fb_tick  (fb_tick),
        .up       (pfd_up),
        .dn       (pfd_dn)
    );

    pllc_lock_det #(.WIN(LOCK_WIN), .PERIODS(LOCK_PERIODS)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .up       (pfd_up),
        .dn       (pfd_dn),
        .ref_tick (cmp_tick),
        .wide     (pulse_wide),
        .locked   (lock_q)
    );

    // Test code decode from enable, P2 and P3.
    always_comb begin
        if (!test_en)           tmode = TM_OFF;
        else if (!port_bits[2]) tmode = TM_PUMP;
        else if (port_bits[3])  tmode = TM_LOCKED;
        else                    tmode = TM_ROUTE;
    end

    // Pump direction and current with test forcing; disable has last word.
    always_comb begin
        if (tmode == TM_PUMP) begin
            up_sel  = port_bits[3];
            dn_sel  = ~port_bits[3];
            pump_hi = ~port_bits[1];
        end else begin
            up_sel  = pfd_up;
            dn_sel  = pfd_dn;
            pump_hi = ~lock_q;
        end
        pump_up = up_sel & ~pump_dis;
        pump_dn = dn_sel & ~pump_dis;
    end

    // Lock flag and port outputs with test forcing and clock routing.
    always_comb begin
        lock_flag = lock_q;
        port_on   = port_bits;
        case (tmode)
            TM_ROUTE: begin
                lock_flag = 1'b0;
                port_on   = {fb_half, cmp_clk, port_bits[1:0]};
            end
            TM_LOCKED: lock_flag = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/pllc_core_chk.sv
// Assertion checker bound to the core top.
module pllc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_en,
    input logic       pump_dis,
    input logic [3:0] port_bits,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       pump_hi,
    input logic       lock_flag,
    input logic [3:0] port_on,
    input logic       cmp_tick,
    input logic       lock_q,
    input logic       pulse_wide
);
    // R3: up and down requests never coexist
    p_pump_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R7: disable silences both requests
    p_pump_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dis |-> (!pump_up && !pump_dn));

    // R11: ports follow programmed bits outside test
    p_port_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (port_on == port_bits));

    // R6: current select mirrors lock outside test
    p_cur_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (pump_hi == !lock_flag));

    // R4: lock only rises right after a comparison event
    p_lock_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(cmp_tick));

    // R5: a wide request clears lock on the next cycle
    p_wide_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_wide |=> !lock_q);

    // R10: forced in-lock code
    p_force_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && port_bits[2] && port_bits[3]) |-> lock_flag);

endmodule

bind pllc_core pllc_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .pump_dis   (pump_dis),
    .port_bits  (port_bits),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_hi    (pump_hi),
    .lock_flag  (lock_flag),
    .port_on    (port_on),
    .cmp_tick   (cmp_tick),
    .lock_q     (lock_q),
    .pulse_wide (pulse_wide)
);

// File: tb/pllc_core_tb_top.sv
module pllc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd4;
    logic        rf_in = 1'b0;
    logic [14:0] divisor = 15'd128;
    logic [3:0]  port_bits = 4'b0000;
    logic        test_en = 1'b0;
    logic        pump_dis = 1'b0;
    logic        pump_up, pump_dn, pump_hi, lock_flag;
    logic [3:0]  port_on;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit rf_run = 1'b0;
    int rf_ph  = 0;

    always #2 clk = ~clk;

    pllc_core dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rf_in(rf_in),
        .divisor(divisor), .port_bits(port_bits), .test_en(test_en),
        .pump_dis(pump_dis), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_hi(pump_hi), .lock_flag(lock_flag), .port_on(port_on)
    );

    // RF stimulus: one rising edge every 4 reference cycles while running.
    always @(negedge clk) begin
        if (rf_run) begin
            rf_ph = (rf_ph + 1) % 2;
            if (rf_ph == 0) rf_in = ~rf_in;
        end else begin
            rf_in = 1'b0;
            rf_ph = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Gap in cycles between two consecutive rises of port_on[idx].
    task automatic rise_gap(input int idx, output int gap);
        logic prev;
        logic cur;
        int   n;
        prev = port_on[idx];
        forever begin
            @(negedge clk); #1;
            cur = port_on[idx];
            if (cur && !prev) break;
            prev = cur;
        end
        prev = 1'b1;
        n = 0;
        forever begin
            @(negedge clk); #1;
            n++;
            cur = port_on[idx];
            if (cur && !prev) break;
            prev = cur;
        end
        gap = n;
    endtask

    // R12: outputs during reset.
    task automatic t_reset_state();
        test_en = 1'b0; pump_dis = 1'b0; rf_run = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); #1;
        chk("R12 up", int'(pump_up), 0);
        chk("R12 dn", int'(pump_dn), 0);
        chk("R12 lock", int'(lock_flag), 0);
        chk("R12 hi", int'(pump_hi), 1);
        rst_n = 1'b1;
    endtask

    // R11: port pass-through.
    task automatic t_ports();
        test_en = 1'b0;
        port_bits = 4'b1010; @(negedge clk); #1;
        chk("R11 ports 1010", int'(port_on), 4'b1010);
        port_bits = 4'b0101; @(negedge clk); #1;
        chk("R11 ports 0101", int'(port_on), 4'b0101);
        port_bits = 4'b0000;
    endtask

    // R3 and R7: PFD direction with stopped and fast feedback; disable.
    task automatic t_pfd();
        mode = 3'd4; divisor = 15'd128; rf_run = 1'b0; test_en = 1'b0;
        apply_reset();
        wait_cyc(600); #1;
        chk("R3 up held with no feedback", int'(pump_up), 1);
        chk("R3 dn low with no feedback", int'(pump_dn), 0);
        pump_dis = 1'b1; @(negedge clk); #1;
        chk("R7 up off", int'(pump_up), 0);
        chk("R7 dn off", int'(pump_dn), 0);
        pump_dis = 1'b0; @(negedge clk); #1;
        chk("R7 state kept after disable", int'(pump_up), 1);
        mode = 3'd1; divisor = 15'd2; rf_run = 1'b1;
        apply_reset();
        wait_cyc(1000); #1;
        chk("R3 dn with fast feedback", int'(pump_dn), 1);
        chk("R3 up low with fast feedback", int'(pump_up), 0);
        rf_run = 1'b0;
    endtask

    // R8 and R7: pump-forcing test codes.
    task automatic t_force_pump();
        test_en = 1'b1;
        port_bits = 4'b0000; @(negedge clk); #1;
        chk("R8 code000 up", int'(pump_up), 0);
        chk("R8 code000 dn", int'(pump_dn), 1);
        chk("R8 code000 hi", int'(pump_hi), 1);
        port_bits = 4'b1000; @(negedge clk); #1;
        chk("R8 code001 up", int'(pump_up), 1);
        chk("R8 code001 hi", int'(pump_hi), 1);
        port_bits = 4'b0010; @(negedge clk); #1;
        chk("R8 code100 dn", int'(pump_dn), 1);
        chk("R8 code100 hi", int'(pump_hi), 0);
        port_bits = 4'b1010; @(negedge clk); #1;
        chk("R8 code101 up", int'(pump_up), 1);
        chk("R8 code101 hi", int'(pump_hi), 0);
        pump_dis = 1'b1; @(negedge clk); #1;
        chk("R7 disable over test up", int'(pump_up), 0);
        chk("R7 disable over test dn", int'(pump_dn), 0);
        pump_dis = 1'b0; test_en = 1'b0; port_bits = 4'b0000;
    endtask

    // R1: comparison period per mode via routing code.
    task automatic t_ref_ratio();
        int g;
        rf_run = 1'b0; mode = 3'd4; test_en = 1'b0;
        apply_reset();
        test_en = 1'b1; port_bits = 4'b0111;
        @(negedge clk); #1;
        chk("R9 low ports pass", int'(port_on[1:0]), 3);
        rise_gap(2, g); chk("R1 mode4 period", g, 512);
        mode = 3'd1;
        rise_gap(2, g); rise_gap(2, g); chk("R1 mode1 period", g, 2048);
        mode = 3'd5;
        rise_gap(2, g); rise_gap(2, g); chk("R1 mode5 as mode0", g, 640);
        mode = 3'd3;
        rise_gap(2, g); rise_gap(2, g); chk("R1 mode3 period", g, 1280);
        test_en = 1'b0; port_bits = 4'b0000; mode = 3'd4;
    endtask

    // R2: feedback divide via halved signal on port 3.
    task automatic t_fb_div();
        int g;
        divisor = 15'd10; rf_run = 1'b1; test_en = 1'b0;
        apply_reset();
        test_en = 1'b1; port_bits = 4'b0100;
        rise_gap(3, g); rise_gap(3, g); chk("R2 divisor 10", g, 80);
        divisor = 15'd0;
        rise_gap(3, g); rise_gap(3, g); chk("R2 divisor 0 as 1", g, 8);
        test_en = 1'b0; port_bits = 4'b0000; rf_run = 1'b0;
    endtask

    // R4, R5, R6, R9, R10: lock acquisition, forcing and loss.
    task automatic t_lock();
        mode = 3'd4; divisor = 15'd128; rf_run = 1'b1; test_en = 1'b0;
        apply_reset();
        wait_cyc(3000); #1;
        chk("R4 not locked after 5 periods", int'(lock_flag), 0);
        chk("R6 high current unlocked", int'(pump_hi), 1);
        wait_cyc(3000); #1;
        chk("R4 locked after 8 clean periods", int'(lock_flag), 1);
        chk("R6 low current locked", int'(pump_hi), 0);
        test_en = 1'b1; port_bits = 4'b0100; @(negedge clk); #1;
        chk("R9 forced out of lock", int'(lock_flag), 0);
        test_en = 1'b0; port_bits = 4'b0000;
        divisor = 15'd136;
        wait_cyc(2000); #1;
        chk("R5 lock lost on wide pulses", int'(lock_flag), 0);
        chk("R6 high current after loss", int'(pump_hi), 1);
        test_en = 1'b1; port_bits = 4'b1100; @(negedge clk); #1;
        chk("R10 forced in lock", int'(lock_flag), 1);
        test_en = 1'b0; port_bits = 4'b0000; rf_run = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_ports();
        t_force_pump();
        t_pfd();
        t_ref_ratio();
        t_fb_div();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule